// File: doc/BRIEF.md
# Peripheral Clock Strobe Generator

This block derives a peripheral clock from one of several source clocks. It divides the chosen source through one or two cascaded 6-bit dividers and gates the result onto one or two outputs. The whole design runs in a single clock domain. Each source clock appears as a one-cycle enable strobe, and each output is a strobe stream that downstream logic uses as a clock enable.

A 32-bit control word carries the source select, the divisors, the output enables and, in one build, an external-bypass select. Source and divisor changes are held in a pending copy. They are applied only when the current divided period ends, so a setting change never produces a shortened period. One build variant moves output gating into a separate disable register two words above the control word. Both registers can be read back.

Top module: `pclk_gen`

## Requirements
- R1: After reset all outputs are low. The control word reads 0x0010_0100, meaning source code 0 in [5:4], divisor 1 in [13:8], divisor 1 in [25:20] and every enable 0. The separate gate register (word address 2) reads 1 when that option is built and 0 otherwise.
- R2: Source field [5:4]: codes 0 and 1 both select `io_tick`, code 2 selects `cpu_tick` and code 3 selects `mem_tick`. Strobes on the unselected sources have no effect on the outputs.
- R3: With first divisor field [13:8] = N (N ≥ 1), one divided strobe is produced for every N strobes of the selected source.
- R4: In the dual-divider build, second divisor field [25:20] = M divides the first stage's output, so the total ratio is N×M.
- R5: A divisor field of 0 is accepted and behaves as divide-by-1.
- R6: Control bit 0 enables output 0 and bit 1 enables output 1, both fed by the same divided stream. A disabled output stays low.
- R7: In the bypass build, control bit 6 = 1 routes `ext_tick` to the gate in place of the divided stream, and bit 6 = 0 routes the divided stream. The enables act after this selection.
- R8: In the separate-gate build, bit 0 of the register at word address 2 disables the output when set, and control bits 0, 1 and 6 are ignored.
- R9: A newly written source or divisor takes effect only after the divided strobe that ends the current period. A mid-period write never shortens or splits that period.
- R10: An output strobe appears on the clock edge that follows the selected-source strobe that completes a period. With no selected-source strobe and no passed-through external strobe, the outputs stay low.
- R11: Readback at `rd_addr` returns the implemented bits of the addressed register and 0 for all other bits and addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_tick | input | 1 | I/O source strobe |
| cpu_tick | input | 1 | CPU-side source strobe |
| mem_tick | input | 1 | Memory-side source strobe |
| ext_tick | input | 1 | External bypass strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register word address (0 control, 2 gate) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Readback word address |
| rd_data | output | DATA_W | Readback data |
| clk_tick | output | NUM_OUT | Gated output strobes |

## Verification
The bench builds two instances that share all inputs. The first has two dividers, two outputs and the external bypass. The second has two dividers, one output and the separate gate register. This combination covers the bypass path and the gate-register path in the same run, and it shows that each build ignores the control bits it does not implement. Because every instance has two dividers, cascaded ratios and zero-valued fields in either divisor can be reached. Settings changed in the middle of a period, together with sparse source patterns, exercise how a setting is applied at the period boundary.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int DIV_W   = 6;
  localparam int SRC_W   = 2;
  localparam int SRC_LSB = 4;
  localparam int D1_LSB  = 8;
  localparam int D2_LSB  = 20;
  localparam int BYP_BIT = 6;

  typedef enum logic [SRC_W-1:0] {
    SRC_IO_A = 2'd0,
    SRC_IO_B = 2'd1,
    SRC_CPU  = 2'd2,
    SRC_MEM  = 2'd3
  } src_e;

  typedef struct packed {
    src_e             src;
    logic [DIV_W-1:0] d1;
    logic [DIV_W-1:0] d2;
  } div_cfg_t;
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs #(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 2,
  parameter int          GATE_WORD = 2,
  parameter bit          SEP_GATE  = 1'b0,
  parameter logic [31:0] CTRL_MASK = 32'h0,
  parameter logic [31:0] CTRL_RST  = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              gate_off
);
  localparam logic [ADDR_W-1:0] CTRL_A = '0;
  localparam logic [ADDR_W-1:0] GATE_A = ADDR_W'(GATE_WORD);

  logic [DATA_W-1:0] ctrl_d;
  logic              ctrl_we;

  assign ctrl_we = wr_en && (wr_addr == CTRL_A);
  assign ctrl_d  = wr_data & CTRL_MASK[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST[DATA_W-1:0];
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  generate
    if (SEP_GATE) begin : g_gate
      logic gate_q;
      logic gate_we;
      assign gate_we = wr_en && (wr_addr == GATE_A);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gate_q <= 1'b1;
        else if (gate_we) gate_q <= wr_data[0];
      end
      assign gate_off = gate_q;
    end else begin : g_nogate
      assign gate_off = 1'b0;
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_A)                 rd_data = ctrl_q;
    else if (SEP_GATE && rd_addr == GATE_A) rd_data[0] = gate_off;
  end

  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_MASK[DATA_W-1:0]) == '0); // R11
endmodule

// File: rtl/pclk_div_stage.sv
module pclk_div_stage #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_tick,
  input  logic [DIV_W-1:0] divisor,
  output logic             out_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, last;

  assign last     = (divisor == '0) ? '0 : divisor - 1'b1;
  assign out_tick = in_tick && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (out_tick)     cnt_d = '0;
    else if (in_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last); // R3
endmodule

// File: rtl/pclk_out_gate.sv
module pclk_out_gate #(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_tick,
  input  logic               ext_tick,
  input  logic               byp_sel,
  input  logic [NUM_OUT-1:0] en,
  output logic [NUM_OUT-1:0] out_q
);
  logic               pre_tick;
  logic [NUM_OUT-1:0] out_d;

  assign pre_tick = byp_sel ? ext_tick : div_tick;

  always_comb begin
    for (int i = 0; i < NUM_OUT; i++) out_d[i] = pre_tick & en[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  AST_QUIET_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_tick && !ext_tick) |=> (out_q == '0)); // R10
  AST_BYP_BLOCKS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_sel && !ext_tick) |=> (out_q == '0)); // R7

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_chk
      AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en[g] |=> !out_q[g]); // R6
    end
  endgenerate
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
  import pclk_pkg::*;
#(
  parameter int NUM_OUT    = 2,
  parameter bit DUAL_DIV   = 1'b1,
  parameter bit EXT_BYPASS = 1'b1,
  parameter bit SEP_GATE   = 1'b0,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int GATE_WORD  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_tick,
  input  logic               cpu_tick,
  input  logic               mem_tick,
  input  logic               ext_tick,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_OUT-1:0] clk_tick
);
  function automatic logic [31:0] ctrl_mask();
    logic [31:0] m;
    m = '0;
    m[SRC_LSB +: SRC_W] = '1;
    m[D1_LSB  +: DIV_W] = '1;
    if (DUAL_DIV)   m[D2_LSB +: DIV_W] = '1;
    if (EXT_BYPASS) m[BYP_BIT] = 1'b1;
    if (!SEP_GATE)  m[NUM_OUT-1:0] = '1;
    return m;
  endfunction

  localparam logic [31:0] CTRL_MASK = ctrl_mask();
  localparam logic [31:0] CTRL_RST  = (32'd1 << D1_LSB) |
                                      (DUAL_DIV ? (32'd1 << D2_LSB) : 32'd0);

  logic [DATA_W-1:0]  ctrl_q;
  logic               gate_off;
  div_cfg_t           act_q, act_d, pend;
  logic               sel_tick, t1, div_tick, byp_sel;
  logic [NUM_OUT-1:0] en;
  logic               unused_ctrl;

  pclk_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GATE_WORD(GATE_WORD),
    .SEP_GATE(SEP_GATE), .CTRL_MASK(CTRL_MASK), .CTRL_RST(CTRL_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctrl_q(ctrl_q), .gate_off(gate_off)
  );

  assign unused_ctrl = ^ctrl_q;

  assign pend.src = src_e'(ctrl_q[SRC_LSB +: SRC_W]);
  assign pend.d1  = ctrl_q[D1_LSB +: DIV_W];
  assign pend.d2  = DUAL_DIV ? ctrl_q[D2_LSB +: DIV_W] : DIV_W'(1);

  always_comb begin
    unique case (act_q.src)
      SRC_IO_A, SRC_IO_B: sel_tick = io_tick;
      SRC_CPU:            sel_tick = cpu_tick;
      default:            sel_tick = mem_tick;
    endcase
  end

  always_comb begin
    act_d = act_q;
    if (div_tick) act_d = pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q.src <= SRC_IO_A;
      act_q.d1  <= DIV_W'(1);
      act_q.d2  <= DIV_W'(1);
    end else begin
      act_q <= act_d;
    end
  end

  pclk_div_stage #(.DIV_W(DIV_W)) u_div1 (
    .clk(clk), .rst_n(rst_n), .in_tick(sel_tick),
    .divisor(act_q.d1), .out_tick(t1)
  );

  generate
    if (DUAL_DIV) begin : g_dual
      pclk_div_stage #(.DIV_W(DIV_W)) u_div2 (
        .clk(clk), .rst_n(rst_n), .in_tick(t1),
        .divisor(act_q.d2), .out_tick(div_tick)
      );
    end else begin : g_single
      logic unused_d2;
      assign unused_d2 = ^act_q.d2;
      assign div_tick  = t1;
    end

    if (EXT_BYPASS) begin : g_byp
      assign byp_sel = ctrl_q[BYP_BIT];
    end else begin : g_nobyp
      assign byp_sel = 1'b0;
    end

    if (SEP_GATE) begin : g_sep
      assign en = {NUM_OUT{~gate_off}};
    end else begin : g_bits
      assign en = ctrl_q[NUM_OUT-1:0];
    end
  endgenerate

  pclk_out_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .ext_tick(ext_tick),
    .byp_sel(byp_sel), .en(en), .out_q(clk_tick)
  );

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !div_tick |=> $stable(act_q)); // R9
  AST_DIV_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> sel_tick); // R10
endmodule

// File: tb/pclk_gen_tb.sv
module pclk_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_tick = 0, cpu_tick = 0, mem_tick = 0, ext_tick = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [1:0]  rd_addr = 0;
  logic [31:0] rd_a, rd_b;
  logic [1:0]  out_a;
  logic [0:0]  out_b;

  always #2 clk = ~clk;

  pclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .io_tick(io_tick), .cpu_tick(cpu_tick),
    .mem_tick(mem_tick), .ext_tick(ext_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_a), .clk_tick(out_a)
  );

  pclk_gen #(.NUM_OUT(1), .DUAL_DIV(1'b1), .EXT_BYPASS(1'b0), .SEP_GATE(1'b1)) u_dut_fab (
    .clk(clk), .rst_n(rst_n), .io_tick(io_tick), .cpu_tick(cpu_tick),
    .mem_tick(mem_tick), .ext_tick(ext_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_b), .clk_tick(out_b)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference state
  logic [31:0] m_ctrl = 32'h0010_0100;
  logic        m_gate = 1'b1;
  int          act_src = 0, act_ratio = 1, cnt = 0;

  logic [2:0] exp_q[$];
  string      req_q[$];
  logic [2:0] pend_exp;
  string      pend_req;
  bit         pend_valid = 0;

  function automatic int fix1(input logic [5:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic logic [31:0] mk(input int src, input int d1, input int d2,
                                     input bit byp, input bit e1, input bit e0);
    return (32'(src) << 4) | (32'(d1) << 8) | (32'(d2) << 20) |
           (32'(byp) << 6) | (32'(e1) << 1) | 32'(e0);
  endfunction

  task automatic step(input bit io, input bit cpu, input bit mem, input bit ext);
    bit sel, dv, pa;
    io_tick = io; cpu_tick = cpu; mem_tick = mem; ext_tick = ext;
    sel = (act_src <= 1) ? io : (act_src == 2) ? cpu : mem;
    dv = 0;
    if (sel) begin
      if (cnt + 1 == act_ratio) begin dv = 1; cnt = 0; end
      else cnt++;
    end
    pa = m_ctrl[6] ? ext : dv;
    pend_exp = {pa & m_ctrl[1], pa & m_ctrl[0], dv & ~m_gate};
    pend_req = cur_req;
    if (dv) begin
      act_src   = int'(m_ctrl[5:4]);
      act_ratio = fix1(m_ctrl[13:8]) * fix1(m_ctrl[25:20]);
    end
    if (wr_en) begin
      if (wr_addr == 2'd0) m_ctrl = wr_data;
      else if (wr_addr == 2'd2) m_gate = wr_data[0];
    end
    @(posedge clk);
    exp_q.push_back(pend_exp);
    req_q.push_back(pend_req);
    @(negedge clk);
    wr_en = 0;
    io_tick = 0; cpu_tick = 0; mem_tick = 0; ext_tick = 0;
  endtask

  // monitor: pops expectations and compares against both instances
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [2:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      vectors++;
      if ({out_a, out_b} !== e) begin
        miscompares++;
        $display("FAIL %s: outputs {a1,a0,b}=%b expected %b at %0t", r, {out_a, out_b}, e, $time);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(0, 0, 0, 0);
  endtask

  task automatic run(input int n, input int pio, input int pcpu, input int pmem, input int pext);
    for (int i = 0; i < n; i++)
      step((i % pio) == 0, (i % pcpu) == 0, (i % pmem) == 1 % pmem, (i % pext) == 0);
  endtask

  task automatic rd_check(input string r, input logic [1:0] a,
                          input logic [31:0] ea, input logic [31:0] eb);
    rd_addr = a;
    #1;
    vectors++;
    if (rd_a !== ea || rd_b !== eb) begin
      miscompares++;
      $display("FAIL %s: readback @%0d a=%h b=%h expected a=%h b=%h", r, a, rd_a, rd_b, ea, eb);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R11: reset values
    rd_check("R1", 2'd0, 32'h0010_0100, 32'h0010_0100);
    rd_check("R1", 2'd2, 32'h0, 32'h1);
    rd_check("R11", 2'd1, 32'h0, 32'h0);
    cur_req = "R1";
    run(12, 1, 1, 1, 1);

    // R3: divide by 3, dense then sparse source
    wr(2'd0, mk(0, 3, 1, 0, 0, 1));
    wr(2'd2, 32'h0);
    cur_req = "R3";
    run(30, 1, 5, 5, 5);
    cur_req = "R10";
    run(30, 2, 1, 1, 7);

    // R2 + R4: cpu source, 2*3 cascade
    wr(2'd0, mk(2, 2, 3, 0, 1, 1));
    cur_req = "R4";
    run(70, 1, 2, 3, 9);
    // R2 + R5: mem source, both zero
    wr(2'd0, mk(3, 0, 0, 0, 1, 1));
    cur_req = "R5";
    run(40, 1, 1, 3, 9);
    // R2: code 1 aliases io, zero first divisor with second = 4
    wr(2'd0, mk(1, 0, 4, 0, 1, 1));
    cur_req = "R2";
    run(50, 2, 1, 1, 9);

    // R9: mid-period change
    wr(2'd0, mk(0, 5, 1, 0, 0, 1));
    cur_req = "R9";
    run(13, 1, 3, 3, 3);
    wr(2'd0, mk(0, 1, 1, 0, 0, 1));
    run(20, 1, 3, 3, 3);
    wr(2'd0, mk(2, 3, 2, 0, 0, 1));
    run(4, 1, 1, 1, 3);
    wr(2'd0, mk(0, 2, 1, 0, 0, 1));
    run(30, 1, 1, 1, 3);

    // R7: bypass to external strobes
    wr(2'd0, mk(0, 2, 1, 1, 1, 1));
    cur_req = "R7";
    run(30, 1, 1, 1, 3);
    // R6: only output 1 enabled
    wr(2'd0, mk(0, 2, 1, 0, 1, 0));
    cur_req = "R6";
    run(20, 1, 1, 1, 3);

    // R8: separate gate register
    wr(2'd2, 32'h1);
    wr(2'd0, mk(0, 2, 1, 0, 1, 1));
    cur_req = "R8";
    run(20, 1, 1, 1, 3);
    wr(2'd2, 32'h0);
    wr(2'd0, mk(0, 3, 1, 1, 0, 0));
    run(20, 1, 1, 1, 2);

    // R11: readback masks
    wr(2'd0, 32'hFFFF_FFFF);
    rd_check("R11", 2'd0, 32'h03F0_3F73, 32'h03F0_3F30);
    wr(2'd2, 32'hFFFF_FFFF);
    rd_check("R11", 2'd2, 32'h0, 32'h1);
    rd_check("R11", 2'd3, 32'h0, 32'h0);
    wr(2'd0, mk(0, 1, 1, 0, 0, 1));
    wr(2'd2, 32'h0);
    cur_req = "R11";
    run(10, 1, 1, 1, 1);

    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule